// File: doc/BRIEF.md
# HDLC Serial Frame Receiver

This block takes a bit-serial line, one bit per cycle in which a strobe is high, and recovers HDLC frames from it. It finds the flags that open and close each frame and removes the zeros the transmitter inserted after runs of ones. It packs the remaining bits into bytes, least significant bit first, and offers each completed byte to an external sink through a request/acknowledge pair. The sink may be a DMA engine or any other consumer.

While bytes arrive, the block runs a 16-bit frame check over them. It also watches the line for abort and idle runs of ones. Reception ends for one of five coded reasons: good frame, check failure, sink overrun, frame too long or abort. At that point the block raises a sticky interrupt with the code and stays halted until a clear command tells it to hunt for the next opening flag. The frame-length limit is set on an 11-bit input. Software programs it to the permitted number of user bytes plus three.

Top module: `hdlc_rx_core`

## Requirements
- R1: A byte sequence between an opening flag (01111110) and a closing flag, at least 3 bytes long and carrying a correct check, ends reception with `irq` high and `status` = 1 (good).
- R2: On the line, a 0 that follows five consecutive 1s is discarded and never becomes a data bit. Data bytes are rebuilt LSB first, and values such as 0xFF and 0x7E arrive intact.
- R3: For every completed byte, the check bytes included, `byte_req` rises with the byte on `byte_data`. Both hold until `byte_ack` is sampled high.
- R4: If a byte completes while `byte_req` is still pending and not being acknowledged in that cycle, reception stops with `status` = 3 (overrun) and `byte_req` drops.
- R5: When the count of completed bytes in a frame would reach `max_len`, reception stops with `status` = 4 (too long). The byte that reaches the limit is not offered, so `max_len`-1 bytes are transferred.
- R6: The check runs CRC-16 (x^16+x^12+x^5+1, preset 0xFFFF, LSB first) over every byte, the check bytes included. A final register other than 0xF0B8, or a frame whose bit count is not a whole number of bytes, ends with `status` = 2.
- R7: Seven consecutive 1s inside a frame after at least one completed byte end reception with `status` = 5 (aborted). If no byte has completed yet, the receiver returns silently to flag hunting.
- R8: `line_idle` goes high once 15 consecutive 1s have been received and drops on the next received 0.
- R9: A closing flag after fewer than 3 bytes raises no interrupt. That flag also serves as the opening flag of the next frame.
- R10: `irq` and `status` hold until `rx_clear`. `rx_clear` then clears both to 0 and returns the receiver to flag hunting.
- R11: While halted with `irq` high, further line input raises no byte request and leaves `status` unchanged.
- R12: After reset, `irq`, `status`, `byte_req` and `line_idle` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_valid | input | 1 | Strobe: `bit_in` carries a line bit this cycle |
| bit_in | input | 1 | Serial line bit |
| max_len | input | LEN_W | Byte-count limit (user bytes plus 3) |
| rx_clear | input | 1 | Clears interrupt and status, resumes hunting |
| byte_req | output | 1 | A completed byte is waiting for the sink |
| byte_data | output | 8 | The waiting byte |
| byte_ack | input | 1 | Sink has taken the waiting byte |
| irq | output | 1 | Reception has stopped |
| status | output | 3 | Stop reason: 0 none, 1 good, 2 check error, 3 overrun, 4 too long, 5 aborted |
| line_idle | output | 1 | Line is in the idle state |

## Verification
The checker watches four properties on every cycle:
- the request handshake: a pending byte stays put until it is acknowledged or reception stops;
- the interrupt: it stays sticky with a frozen status until a clear, and a clear takes it back to zero;
- the request line stays quiet while halted;
- `line_idle` drops on any received zero.

Other behaviour depends on bit patterns over many cycles, so only the bench scenarios can show it. This covers zero deletion, the exact value of the check residue, the byte-length boundary against `max_len`, abort before versus after the first byte, silent discard of short frames, and the overrun decision.

// File: rtl/hdlc_rx_pkg.sv
`timescale 1ns/1ps
package hdlc_rx_pkg;

    localparam int OCTET      = 8;
    localparam int STUFF_RUN  = 5;   // ones after which a zero is inserted
    localparam int FLAG_RUN   = 6;   // ones inside a flag
    localparam int ABORT_RUN  = 7;   // ones that mark an abort
    localparam int IDLE_RUN   = 15;  // ones that mark an idle line
    localparam int LAG        = STUFF_RUN + 1; // flag bits seen as data before detection
    localparam int MIN_FRAME  = 3;   // fewest bytes of a kept frame
    localparam int CRC_W      = 16;
    localparam logic [CRC_W-1:0] CRC_POLY_REV = 16'h8408;
    localparam logic [CRC_W-1:0] CRC_INIT     = 16'hFFFF;
    localparam logic [CRC_W-1:0] CRC_RESIDUE  = 16'hF0B8;

    typedef enum logic [2:0] {
        ST_NONE     = 3'd0,
        ST_GOOD     = 3'd1,
        ST_FCS_BAD  = 3'd2,
        ST_OVERRUN  = 3'd3,
        ST_TOO_LONG = 3'd4,
        ST_ABORTED  = 3'd5
    } rx_status_e;

    typedef enum logic [1:0] {
        RX_HUNT,
        RX_FRAME,
        RX_HALT
    } rx_state_e;

    typedef struct packed {
        logic flag;
        logic abort;
        logic data_en;
        logic data_bit;
    } line_evt_t;

    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                  input logic [OCTET-1:0] b);
        logic [CRC_W-1:0] r;
        r = c;
        for (int k = 0; k < OCTET; k++) begin
            if (r[0] ^ b[k]) r = (r >> 1) ^ CRC_POLY_REV;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/hdlc_rx_linecode.sv
`timescale 1ns/1ps
module hdlc_rx_linecode
    import hdlc_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      bit_valid,
    input  logic      bit_in,
    output line_evt_t evt,
    output logic      line_idle
);
    localparam int ONES_W = $clog2(IDLE_RUN + 1);
    localparam logic [ONES_W-1:0] ONES_MAX = ONES_W'(IDLE_RUN);

    logic [ONES_W-1:0] ones_q;
    logic [ONES_W-1:0] ones_inc;

    assign ones_inc = (ones_q == ONES_MAX) ? ONES_MAX : ones_q + 1'b1;

    always_comb begin
        evt = '0;
        evt.data_bit = bit_in;
        if (bit_valid) begin
            if (bit_in) begin
                evt.data_en = (ones_inc <= ONES_W'(STUFF_RUN));
                evt.abort   = (ones_inc == ONES_W'(ABORT_RUN));
            end else begin
                evt.flag    = (ones_q == ONES_W'(FLAG_RUN));
                evt.data_en = (ones_q <  ONES_W'(STUFF_RUN));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ones_q <= '0;
        end else if (bit_valid) begin
            ones_q <= bit_in ? ones_inc : '0;
        end
    end

    assign line_idle = (ones_q == ONES_MAX);

endmodule

// File: rtl/hdlc_rx_octet.sv
`timescale 1ns/1ps
module hdlc_rx_octet
    import hdlc_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             bit_en,
    input  logic             bit_val,
    output logic             byte_done,
    output logic [OCTET-1:0] byte_val,
    output logic             aligned
);
    localparam int SR_W  = OCTET + LAG;
    localparam int CNT_W = $clog2(SR_W + 1);

    logic [SR_W-1:0]  sr_q;
    logic [SR_W-1:0]  sr_n;
    logic [CNT_W-1:0] cnt_q;

    assign sr_n      = {bit_val, sr_q[SR_W-1:1]};
    assign byte_done = bit_en && (cnt_q == CNT_W'(SR_W - 1));
    assign byte_val  = sr_n[OCTET-1:0];
    assign aligned   = (cnt_q == CNT_W'(LAG));

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q  <= '0;
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (bit_en) begin
            sr_q  <= sr_n;
            cnt_q <= byte_done ? CNT_W'(LAG) : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/hdlc_rx_fcs.sv
`timescale 1ns/1ps
module hdlc_rx_fcs
    import hdlc_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             upd,
    input  logic [OCTET-1:0] byte_in,
    output logic             ok
);
    logic [CRC_W-1:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            crc_q <= CRC_INIT;
        end else if (upd) begin
            crc_q <= crc_step(crc_q, byte_in);
        end
    end

    assign ok = (crc_q == CRC_RESIDUE);

endmodule

// File: rtl/hdlc_rx_core.sv
`timescale 1ns/1ps
module hdlc_rx_core
    import hdlc_rx_pkg::*;
#(
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_valid,
    input  logic             bit_in,
    input  logic [LEN_W-1:0] max_len,
    input  logic             rx_clear,
    output logic             byte_req,
    output logic [7:0]       byte_data,
    input  logic             byte_ack,
    output logic             irq,
    output logic [2:0]       status,
    output logic             line_idle
);
    line_evt_t        evt;
    logic             byte_done;
    logic [OCTET-1:0] byte_val;
    logic             aligned;
    logic             crc_ok;

    rx_state_e        state_q;
    rx_status_e       status_q;
    logic             irq_q;
    logic             req_q;
    logic [OCTET-1:0] data_q;
    logic [LEN_W-1:0] count_q;
    logic [LEN_W-1:0] count_inc;
    logic             sink_busy;

    hdlc_rx_linecode u_line (
        .clk       (clk),
        .rst       (rst),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .evt       (evt),
        .line_idle (line_idle)
    );

    hdlc_rx_octet u_octet (
        .clk       (clk),
        .rst       (rst),
        .clr       (evt.flag),
        .bit_en    (evt.data_en),
        .bit_val   (evt.data_bit),
        .byte_done (byte_done),
        .byte_val  (byte_val),
        .aligned   (aligned)
    );

    hdlc_rx_fcs u_fcs (
        .clk     (clk),
        .rst     (rst),
        .clr     (evt.flag),
        .upd     (byte_done),
        .byte_in (byte_val),
        .ok      (crc_ok)
    );

    assign count_inc = count_q + 1'b1;
    assign sink_busy = req_q && !byte_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= RX_HUNT;
            status_q <= ST_NONE;
            irq_q    <= 1'b0;
            req_q    <= 1'b0;
            data_q   <= '0;
            count_q  <= '0;
        end else begin
            if (req_q && byte_ack) req_q <= 1'b0;
            unique case (state_q)
                RX_HUNT: begin
                    if (evt.flag) begin
                        state_q <= RX_FRAME;
                        count_q <= '0;
                    end
                end
                RX_FRAME: begin
                    if (evt.flag) begin
                        if (count_q < LEN_W'(MIN_FRAME)) begin
                            count_q <= '0;
                        end else begin
                            state_q  <= RX_HALT;
                            irq_q    <= 1'b1;
                            req_q    <= 1'b0;
                            status_q <= (crc_ok && aligned) ? ST_GOOD : ST_FCS_BAD;
                        end
                    end else if (evt.abort) begin
                        if (count_q == '0) begin
                            state_q <= RX_HUNT;
                        end else begin
                            state_q  <= RX_HALT;
                            irq_q    <= 1'b1;
                            req_q    <= 1'b0;
                            status_q <= ST_ABORTED;
                        end
                    end else if (byte_done) begin
                        if (sink_busy) begin
                            state_q  <= RX_HALT;
                            irq_q    <= 1'b1;
                            req_q    <= 1'b0;
                            status_q <= ST_OVERRUN;
                        end else if (count_inc == max_len) begin
                            state_q  <= RX_HALT;
                            irq_q    <= 1'b1;
                            req_q    <= 1'b0;
                            status_q <= ST_TOO_LONG;
                        end else begin
                            req_q   <= 1'b1;
                            data_q  <= byte_val;
                            count_q <= count_inc;
                        end
                    end
                end
                RX_HALT: begin
                    req_q <= 1'b0;
                    if (rx_clear) begin
                        state_q  <= RX_HUNT;
                        irq_q    <= 1'b0;
                        status_q <= ST_NONE;
                    end
                end
                default: state_q <= RX_HUNT;
            endcase
        end
    end

    assign byte_req  = req_q;
    assign byte_data = data_q;
    assign irq       = irq_q;
    assign status    = status_q;

endmodule

// File: rtl/hdlc_rx_core_chk.sv
`timescale 1ns/1ps
module hdlc_rx_core_chk (
    input logic       clk,
    input logic       rst,
    input logic       bit_valid,
    input logic       bit_in,
    input logic       rx_clear,
    input logic       byte_req,
    input logic [7:0] byte_data,
    input logic       byte_ack,
    input logic       irq,
    input logic [2:0] status,
    input logic       line_idle
);
    a_r3_req_held: assert property (@(posedge clk) disable iff (rst)
        byte_req && !byte_ack |=> byte_req || irq);

    a_r3_data_stable: assert property (@(posedge clk) disable iff (rst)
        byte_req && !byte_ack |=> $stable(byte_data));

    a_r10_irq_sticky: assert property (@(posedge clk) disable iff (rst)
        irq && !rx_clear |=> irq && $stable(status));

    a_r10_clear: assert property (@(posedge clk) disable iff (rst)
        irq && rx_clear |=> !irq && status == 3'd0);

    a_r10_code_valid: assert property (@(posedge clk) disable iff (rst)
        irq |-> status >= 3'd1 && status <= 3'd5);

    a_r10_no_code_idle: assert property (@(posedge clk) disable iff (rst)
        !irq |-> status == 3'd0);

    a_r11_quiet_halt: assert property (@(posedge clk) disable iff (rst)
        irq |-> !byte_req);

    a_r8_idle_drop: assert property (@(posedge clk) disable iff (rst)
        bit_valid && !bit_in |=> !line_idle);

endmodule

bind hdlc_rx_core hdlc_rx_core_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bit_valid (bit_valid),
    .bit_in    (bit_in),
    .rx_clear  (rx_clear),
    .byte_req  (byte_req),
    .byte_data (byte_data),
    .byte_ack  (byte_ack),
    .irq       (irq),
    .status    (status),
    .line_idle (line_idle)
);

// File: tb/hdlc_rx_core_bench.sv
`timescale 1ns/1ps
module hdlc_rx_core_bench;
    localparam int LEN_W = 11;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             bit_valid = 1'b0;
    logic             bit_in = 1'b1;
    logic [LEN_W-1:0] max_len = 11'd2047;
    logic             rx_clear = 1'b0;
    logic             byte_req;
    logic [7:0]       byte_data;
    logic             byte_ack = 1'b0;
    logic             irq;
    logic [2:0]       status;
    logic             line_idle;

    int n_chk = 0;
    int n_bad = 0;
    int tx_ones = 0;
    bit auto_ack = 1'b1;
    bit done = 1'b0;
    logic [7:0] cap [0:63];
    int n_cap = 0;
    logic [7:0] expb [0:63];
    int n_exp = 0;

    always #10 clk = ~clk;

    hdlc_rx_core #(.LEN_W(LEN_W)) u_hdlc_rx_core (
        .clk       (clk),
        .rst       (rst),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .max_len   (max_len),
        .rx_clear  (rx_clear),
        .byte_req  (byte_req),
        .byte_data (byte_data),
        .byte_ack  (byte_ack),
        .irq       (irq),
        .status    (status),
        .line_idle (line_idle)
    );

    // byte sink model
    initial begin
        forever begin
            @(negedge clk);
            if (auto_ack && byte_req && !byte_ack) begin
                if (n_cap < 64) cap[n_cap] = byte_data;
                n_cap++;
                byte_ack = 1'b1;
            end else begin
                byte_ack = 1'b0;
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] v);
        logic [15:0] r;
        r = c;
        for (int k = 0; k < 8; k++) begin
            r = (r[0] != v[k]) ? ((r >> 1) ^ 16'h8408) : (r >> 1);
        end
        return r;
    endfunction

    function automatic logic [7:0] pat(input int s, input int i);
        case (i % 4)
            0:       return 8'hFF;
            1:       return 8'h7E;
            2:       return 8'((s * 29 + i * 13) & 255);
            default: return 8'hF8 ^ 8'(s);
        endcase
    endfunction

    task automatic send_line(input logic b);
        bit_in = b;
        bit_valid = 1'b1;
        @(posedge clk); #1;
        bit_valid = 1'b0;
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic send_flag();
        send_line(1'b0);
        for (int k = 0; k < 6; k++) send_line(1'b1);
        send_line(1'b0);
        tx_ones = 0;
    endtask

    task automatic send_dbit(input logic b);
        send_line(b);
        if (b) begin
            tx_ones++;
            if (tx_ones == 5) begin
                send_line(1'b0);
                tx_ones = 0;
            end
        end else begin
            tx_ones = 0;
        end
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int k = 0; k < 8; k++) send_dbit(v[k]);
    endtask

    task automatic settle();
        repeat (12) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_clear();
        @(posedge clk); #1;
        rx_clear = 1'b1;
        @(posedge clk); #1;
        rx_clear = 1'b0;
        @(negedge clk);
    endtask

    // frame of n data bytes plus check bytes; bad flips one check bit
    task automatic run_frame(input int n, input int seed, input bit bad);
        logic [15:0] c;
        logic [15:0] f;
        c = 16'hFFFF;
        n_exp = 0;
        for (int i = 0; i < n; i++) begin
            expb[n_exp] = pat(seed, i);
            c = ref_crc(c, expb[n_exp]);
            n_exp++;
        end
        f = ~c;
        if (bad) f[0] = ~f[0];
        expb[n_exp] = f[7:0];  n_exp++;
        expb[n_exp] = f[15:8]; n_exp++;
        send_flag();
        for (int i = 0; i < n_exp; i++) send_byte(expb[i]);
        send_flag();
        settle();
    endtask

    initial begin
        int mism;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check("R12 irq", int'(irq), 0);
        check("R12 status", int'(status), 0);
        check("R12 byte_req", int'(byte_req), 0);
        check("R12 line_idle", int'(line_idle), 0);

        // idle detection
        for (int k = 0; k < 14; k++) send_line(1'b1);
        @(negedge clk);
        check("R8 idle after 14 ones", int'(line_idle), 0);
        send_line(1'b1);
        @(negedge clk);
        check("R8 idle after 15 ones", int'(line_idle), 1);
        send_line(1'b0);
        @(negedge clk);
        check("R8 idle dropped on zero", int'(line_idle), 0);

        // length sweep: limit just above, then exactly at, total byte count
        for (int n = 1; n <= 10; n++) begin
            max_len = LEN_W'(n + 3);
            n_cap = 0;
            run_frame(n, n, 1'b0);
            check("R1 irq good frame", int'(irq), 1);
            check("R1 status good", int'(status), 1);
            check("R3 bytes offered", n_cap, n + 2);
            mism = 0;
            for (int i = 0; i < n + 2; i++) if (cap[i] !== expb[i]) mism++;
            check("R2 destuffed bytes match", mism, 0);
            pulse_clear();
            check("R10 irq cleared", int'(irq), 0);
            check("R10 status cleared", int'(status), 0);

            max_len = LEN_W'(n + 2);
            n_cap = 0;
            run_frame(n, n + 40, 1'b0);
            check("R5 status too long", int'(status), 4);
            check("R5 bytes before limit", n_cap, n + 1);
            pulse_clear();
        end
        max_len = 11'd2047;

        // check error
        run_frame(4, 7, 1'b1);
        check("R6 bad check status", int'(status), 2);
        pulse_clear();

        // non-octet frame
        send_flag();
        send_byte(8'h12); send_byte(8'h34); send_byte(8'h56);
        send_dbit(1'b0); send_dbit(1'b1); send_dbit(1'b0);
        send_flag();
        settle();
        check("R6 non-octet status", int'(status), 2);
        pulse_clear();

        // short frame discarded, closing flag opens next frame
        n_cap = 0;
        send_flag();
        send_byte(8'h0F); send_byte(8'hF0);
        send_flag();
        settle();
        check("R9 short frame no irq", int'(irq), 0);
        for (int i = 0; i < 3; i++) send_byte(8'h5A + 8'(i));
        begin
            logic [15:0] c;
            c = 16'hFFFF;
            for (int i = 0; i < 3; i++) c = ref_crc(c, 8'h5A + 8'(i));
            c = ~c;
            send_byte(c[7:0]); send_byte(c[15:8]);
        end
        send_flag();
        settle();
        check("R9 shared flag frame good", int'(status), 1);
        pulse_clear();

        // overrun
        auto_ack = 1'b0;
        n_cap = 0;
        run_frame(3, 3, 1'b0);
        check("R4 overrun status", int'(status), 3);
        check("R4 request dropped", int'(byte_req), 0);
        auto_ack = 1'b1;
        run_frame(2, 9, 1'b0);
        check("R11 no bytes while halted", n_cap, 0);
        check("R11 status unchanged", int'(status), 3);
        check("R11 irq held", int'(irq), 1);
        pulse_clear();

        // abort after data
        send_flag();
        send_byte(8'h55); send_byte(8'hA3);
        for (int k = 0; k < 7; k++) send_line(1'b1);
        send_line(1'b0);
        settle();
        check("R7 abort status", int'(status), 5);
        pulse_clear();

        // abort before any byte is silent
        send_flag();
        for (int k = 0; k < 8; k++) send_line(1'b1);
        send_line(1'b0);
        settle();
        check("R7 early abort no irq", int'(irq), 0);
        run_frame(2, 5, 1'b0);
        check("R7 hunting resumed", int'(status), 1);
        pulse_clear();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule